// File: doc/BRIEF.md
# Transmit Bit Retiming Interface

This block sits between a host controller and an FSK modulator on a 1200 bit/s transmit path. It lets the host send serial data one bit at a time, with no UART. The host presents a data level and a strobe. A rising strobe edge loads the data level into a holding stage. A bit-rate tick, divided down from the system clock, moves the held bit into the output stage.

The strobe line also selects the mode. Its level is examined at every tick. If the strobe is high at a tick, the block runs in direct mode and the host data level goes straight to the modulator. If the strobe is low at a tick, the block runs in retimed mode. The modulator then sees the output stage, and an active-low request flag asks the host for the next bit. Any high level on the strobe clears that request. A host that keeps the strobe high therefore never sees a request, and retiming stays off.

Both host inputs are asynchronous and each passes through a synchroniser. The mode flag changes only at a tick. As a result, the modulator input changes only at a tick, or when the host data changes while the block is in direct mode.

Top module: `tx_bit_retimer`

## Requirements
- R1: While reset is low, and after its release, the modulator bit is mark (1), the request flag is high (inactive), and the block is in direct mode.
- R2: When the strobe was high at the last tick (direct mode), the modulator bit follows the host data pin with a latency of SYNC_STAGES system clock edges.
- R3: While the strobe pin is held high, the request flag never goes low across any number of ticks.
- R4: Ticks take effect at the TICK_DIV-th rising system clock edge after reset release, and then at every further TICK_DIV edges. TICK_DIV equals SYS_CLK_HZ / BIT_RATE_HZ.
- R5: A rising edge of the synchronised strobe loads the synchronised host data into the holding stage at the edge after the synchronised strobe first reads high. With SYNC_STAGES = 2, that is the third edge after the pin rises.
- R6: At a tick, the holding stage is copied into the output stage. If the synchronised strobe is low at that tick, the block enters retimed mode, the modulator bit becomes the output stage, and the request flag goes low at that edge.
- R7: The request flag returns high at the first edge at which the synchronised strobe reads high, which is the third edge after the pin rises.
- R8: The mode flag changes only at ticks. Between ticks in retimed mode, changes on the host data pin do not reach the modulator bit. A strobe drop does not end direct mode before the next tick.
- R9: When a strobe load and a tick fall on the same edge, the tick copies the previous holding content. The newly loaded bit stays held and is released at the following tick. Because the strobe is high at that tick, the block is left in direct mode with the request flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data_i | input | 1 | Asynchronous serial data level from the host |
| host_strobe_i | input | 1 | Asynchronous host strobe: its rising edge loads a bit, and its level at a tick selects the mode |
| mod_bit_o | output | 1 | Data bit to the FSK modulator |
| bit_req_n_o | output | 1 | Active-low request for the next bit |

## Verification
The two functions that can fall in the same cycle are a strobe load into the holding stage and a tick transfer out of it. To make them coincide, the bench raises the strobe pin exactly three edges before a computed tick edge. It then judges the result at the ports in four ways:
- the request flag stays high at that tick;
- the host data pin is still passed through after the strobe drops, up to the next tick;
- the newly loaded bit appears at that next tick;
- the request flag falls at that next tick.

// File: rtl/txr_pkg.sv
// Package: shared types and constants for the transmit bit retimer.
// Assumes: nothing beyond IEEE 1800-2017.
package txr_pkg;

    // Output source selection held between ticks
    typedef enum logic {
        TXR_DIRECT  = 1'b0,
        TXR_RETIMED = 1'b1
    } txr_mode_e;

    // Idle line level of the serial data path
    localparam logic TXR_MARK = 1'b1;

endpackage

// File: rtl/txr_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level (phases of many clocks),
// so only metastability, not data loss, is a concern.
module txr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First flop samples the asynchronous pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                // Later flops settle the sampled level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= RST_VAL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/txr_rise_det.sv
// Module: rising-edge detector on an already synchronised level.
// Assumes: the input is synchronous to clk; the reset value matches the
// idle level so that no false edge appears after reset.
module txr_rise_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/txr_tick_gen.sv
// Module: bit-rate tick generator; one-cycle pulse every DIV clocks.
// Assumes: DIV >= 2. The count restarts at reset, so the first tick acts
// on the DIV-th edge after reset release.
module txr_tick_gen #(
    parameter int DIV = 83333
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running modulo-DIV counter
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/txr_retime_core.sv
// Module: two-stage bit buffer, mode flag and request flag.
// Assumes: strobe/data are synchronised; load and tick are single-cycle
// pulses. On a coincident load and tick, the tick copies the old holding value.
module txr_retime_core
    import txr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      load_i,
    input  logic      strobe_i,
    input  logic      data_i,
    output logic      hold_o,
    output logic      stage_o,
    output txr_mode_e mode_o,
    output logic      mod_bit_o,
    output logic      req_n_o
);

    logic      hold_q;
    logic      stage_q;
    txr_mode_e mode_q;
    logic      req_n_q;

    // Holding stage: capture host data on a strobe rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= TXR_MARK;
        else if (load_i) hold_q <= data_i;
    end

    // Output stage: take the holding value at each tick
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= TXR_MARK;
        else if (tick_i) stage_q <= hold_q;
    end

    // Mode flag: strobe level at the tick picks direct or retimed
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= TXR_DIRECT;
        else if (tick_i) mode_q <= strobe_i ? TXR_DIRECT : TXR_RETIMED;
    end

    // Request flag: set low at a tick with strobe low, cleared by strobe high
    always_ff @(posedge clk) begin
        if (!rst_n)        req_n_q <= 1'b1;
        else if (strobe_i) req_n_q <= 1'b1;
        else if (tick_i)   req_n_q <= 1'b0;
    end

    // Modulator source selection
    always_comb begin
        if (mode_q == TXR_RETIMED) mod_bit_o = stage_q;
        else                       mod_bit_o = data_i;
    end

    assign hold_o  = hold_q;
    assign stage_o = stage_q;
    assign mode_o  = mode_q;
    assign req_n_o = req_n_q;

endmodule

// File: rtl/tx_bit_retimer.sv
// Module: top of the transmit bit retiming interface.
// Assumes: SYS_CLK_HZ is an integer multiple of BIT_RATE_HZ, at least twice
// it; host strobe phases last longer than SYNC_STAGES + 1 system clocks.
module tx_bit_retimer
    import txr_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int BIT_RATE_HZ = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_data_i,
    input  logic host_strobe_i,
    output logic mod_bit_o,
    output logic bit_req_n_o
);

    localparam int TICK_DIV = SYS_CLK_HZ / BIT_RATE_HZ;

    logic      data_s;
    logic      strobe_s;
    logic      strobe_rise;
    logic      bit_tick;
    logic      hold_q;
    logic      stage_q;
    txr_mode_e mode_q;

    txr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(TXR_MARK)) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (host_data_i),
        .sync_o  (data_s)
    );

    txr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (host_strobe_i),
        .sync_o  (strobe_s)
    );

    txr_rise_det #(.RST_VAL(1'b1)) u_strobe_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (strobe_s),
        .rise_o  (strobe_rise)
    );

    txr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (bit_tick)
    );

    txr_retime_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (bit_tick),
        .load_i    (strobe_rise),
        .strobe_i  (strobe_s),
        .data_i    (data_s),
        .hold_o    (hold_q),
        .stage_o   (stage_q),
        .mode_o    (mode_q),
        .mod_bit_o (mod_bit_o),
        .req_n_o   (bit_req_n_o)
    );

endmodule

// File: rtl/txr_retimer_checker.sv
// Module: property checker for tx_bit_retimer, attached by bind.
// Assumes: the tick divider is at least 2.
module txr_retimer_checker
    import txr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      load,
    input logic      strobe_s,
    input logic      data_s,
    input logic      hold_q,
    input logic      stage_q,
    input txr_mode_e mode_q,
    input logic      mod_bit,
    input logic      req_n
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (req_n && mode_q == TXR_DIRECT && stage_q)); // R1
    AST_DIRECT_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (tick && strobe_s) |=> mode_q == TXR_DIRECT); // R2
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R4
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) load |=> hold_q == $past(data_s)); // R5
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(hold_q)); // R5
    AST_TICK_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n) tick |=> stage_q == $past(hold_q)); // R6
    AST_REQ_FALL_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(req_n) |-> ($past(tick) && !$past(strobe_s))); // R6
    AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) strobe_s |=> req_n); // R7
    AST_MODE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(mode_q)); // R8
    AST_RETIMED_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == TXR_RETIMED && !tick) |=> $stable(mod_bit)); // R8

endmodule

bind tx_bit_retimer txr_retimer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .load     (strobe_rise),
    .strobe_s (strobe_s),
    .data_s   (data_s),
    .hold_q   (hold_q),
    .stage_q  (stage_q),
    .mode_q   (mode_q),
    .mod_bit  (mod_bit_o),
    .req_n    (bit_req_n_o)
);

// File: tb/tx_bit_retimer_bench.sv
module tx_bit_retimer_bench;

    localparam int DIV = 16;   // 19200 / 1200
    localparam int NVEC = 8;
    // {stimulus bit, expected modulator bit after its tick}
    localparam logic [1:0] VEC [NVEC] = '{2'b00, 2'b11, 2'b11, 2'b00,
                                          2'b00, 2'b11, 2'b00, 2'b11};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_data = 1'b1;
    logic host_strobe = 1'b1;
    logic mod_bit;
    logic req_n;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    // Edges since reset release
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tx_bit_retimer #(.SYS_CLK_HZ(19200), .BIT_RATE_HZ(1200), .SYNC_STAGES(2)) u_tx_bit_retimer (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_data_i   (host_data),
        .host_strobe_i (host_strobe),
        .mod_bit_o     (mod_bit),
        .bit_req_n_o   (req_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    task automatic go_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        int   t0;
        logic prev;
        logic nb;
        bit   req_seen_low;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 bit in reset", mod_bit, 1'b1);
        chk("R1 request in reset", req_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bit after release", mod_bit, 1'b1);
        // R2: direct pass-through with two-edge latency
        go_to(2);  host_data = 1'b0;
        go_to(3);  chk("R2 latency not yet", mod_bit, 1'b1);
        go_to(4);  chk("R2 follows data low", mod_bit, 1'b0);
        go_to(10); host_data = 1'b1;
        go_to(12); chk("R2 follows data high", mod_bit, 1'b1);
        go_to(20); host_data = 1'b0;
        go_to(22); chk("R2 follows data low again", mod_bit, 1'b0);
        // R3: request stays inactive over several ticks with strobe high
        req_seen_low = 1'b0;
        while (cyc < 40) begin
            if (req_n !== 1'b1) req_seen_low = 1'b1;
            @(negedge clk);
        end
        chk("R3 no request while strobe high", req_seen_low, 1'b0);
        // R4/R6/R8: drop strobe at 40, first retimed tick at 48
        host_strobe = 1'b0;
        go_to(47);
        chk("R4 request before tick", req_n, 1'b1);
        chk("R8 still direct before tick", mod_bit, 1'b0);
        go_to(48);
        chk("R4 request at tick", req_n, 1'b0);
        chk("R6 output stage mark", mod_bit, 1'b1);
        // Table walk: one bit per tick via strobe handshake
        t0 = 48;
        prev = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            host_data = VEC[i][1];
            go_to(t0 + 3);  host_strobe = 1'b1;
            go_to(t0 + 5);  chk("R7 request still low", req_n, 1'b0);
            go_to(t0 + 6);  chk("R7 request cleared", req_n, 1'b1);
            go_to(t0 + 7);  host_strobe = 1'b0;
            go_to(t0 + 10); host_data = ~VEC[i][1];
            go_to(t0 + 15); chk("R8 output held between ticks", mod_bit, prev);
            go_to(t0 + 16);
            chk("R6 bit released at tick", mod_bit, VEC[i][0]);
            chk("R6 request at tick", req_n, 1'b0);
            prev = VEC[i][0];
            t0 += 16;
        end
        // R9: strobe load coinciding with tick at t0+16
        nb = ~prev;
        host_data = nb;
        go_to(t0 + 13); host_strobe = 1'b1;
        go_to(t0 + 15); chk("R9 before coincident tick", mod_bit, prev);
        go_to(t0 + 16);
        chk("R9 request high at coincident tick", req_n, 1'b1);
        chk("R9 direct mode at coincident tick", mod_bit, nb);
        host_data = prev;
        go_to(t0 + 17); host_strobe = 1'b0;
        go_to(t0 + 19); chk("R8 direct kept after strobe drop", mod_bit, prev);
        go_to(t0 + 31); chk("R8 request high before tick", req_n, 1'b1);
        go_to(t0 + 32);
        chk("R9 loaded bit released next tick", mod_bit, nb);
        chk("R9 request at next tick", req_n, 1'b0);
        // R1: reset during retimed operation
        host_data = 1'b0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 bit on mid-run reset", mod_bit, 1'b1);
        chk("R1 request on mid-run reset", req_n, 1'b1);
        host_strobe = 1'b1;
        rst_n = 1'b1;
        go_to(2);
        chk("R2 direct after mid-run reset", mod_bit, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule